// File: doc/BRIEF.md
# Zero-Wait-State Byte-Strobed Memory Slave

This block answers read and write cycles from a 16-bit processor bus that uses an active-low address strobe, a read/write line and two active-low byte strobes instead of an address bit 0. It holds a small word-wide memory array inside itself. The handshake is answered with an active-low transfer acknowledge, and the block never adds wait states.

A read loads the addressed word into an output register on the same rising edge that asserts acknowledge. The word is driven onto the data bus only while the cycle is still open. A write takes the data and its byte selects into a holding register on that same edge and acknowledges at once. The array is updated on the following edge, so the write is posted. The master closes each cycle by raising its strobes. The block then stops driving the bus in the same instant, and acknowledge returns high on the next rising edge.

The 3-bit function code that comes with each cycle is registered and brought out. Nothing else in the block uses it. All bus inputs are taken to be synchronous to `clk`, with setup met at the rising edge.

Top module: `strobe_mem_slave`

## Requirements
- R1: While `rstN` is low, and right after it rises, `dtackN` is 1, `rdOe` is 0, `rdData` is 0, `cycleFc` is 0 and every array word reads back as 0.
- R2: A cycle starts at the rising edge where `asN` is 0 and at least one of `udsN`/`ldsN` is 0 while no cycle is open. `dtackN` goes to 0 on that edge. When `asN` is 0 but both byte strobes are 1, `dtackN` stays 1.
- R3: On a read (`rwN`=1), the full 16-bit addressed word is in `rdData` from the edge that asserts `dtackN`. It stays unchanged until the cycle closes.
- R4: `rdOe` is 1 exactly when a cycle is open (acknowledge issued), that cycle is a read, and `asN` is 0. It falls as soon as `asN` rises, with no clock edge in between. `rdData` is 0 whenever `rdOe` is 0.
- R5: `dtackN` returns to 1 at the first rising edge at which `asN` is sampled high, which comes after `rdOe` has already dropped.
- R6: The write data and byte selects are taken at the acknowledging edge. Changes on `wrData` after that edge have no effect on the array.
- R7: A write is committed to the array on the rising edge after the acknowledging edge. `udsN`=0 selects bits 15:8 and `ldsN`=0 selects bits 7:0. An unselected byte keeps its old value.
- R8: A read that starts right after a write to the same word returns the newly written bytes, because a posted write always lands before the next cycle can start.
- R9: `cycleFc` takes `fc` when a cycle starts and holds it until the next cycle starts. The function code changes nothing else.
- R10: The word index is the low log2(`MEM_WORDS`) bits of `busAddr`, where `busAddr[0]` is byte-address bit 1. Higher bits are ignored, so addresses that differ only above the index alias to the same word.
- R11: Address, `rwN` and byte-strobe changes made while a cycle is open have no effect on that cycle's data or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| asN | input | 1 | Address strobe, active low |
| rwN | input | 1 | 1 = read, 0 = write |
| udsN | input | 1 | Upper byte strobe (bits 15:8), active low |
| ldsN | input | 1 | Lower byte strobe (bits 7:0), active low |
| busAddr | input | ADDR_W | Word address (byte-address bits 1 and up) |
| fc | input | FC_W | Function code of the cycle |
| wrData | input | 16 | Write data from the master |
| dtackN | output | 1 | Transfer acknowledge, active low |
| rdData | output | 16 | Read data, 0 when not driven |
| rdOe | output | 1 | Drive enable for the read data bus |
| cycleFc | output | FC_W | Registered function code of the latest cycle |

## Verification
The bench builds the block with the full 23-bit word address and `MEM_WORDS` set to 16. With that depth, addresses that differ only in high bits reach the same word, so aliasing shows up in a short run, and every word can be visited. The bench runs byte-lane merges, a read straight after a write, and strobe-without-lane cycles. It also changes the address and write data in mid-cycle. A behavioural model is compared against the outputs on every clock.

// File: rtl/strobe_mem_pkg.sv
package strobe_mem_pkg;

  // Data bus geometry: two byte lanes, one per byte strobe
  localparam int BUS_W  = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = BUS_W / LANE_W;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;    // a cycle opens on this edge
    logic captureWr;  // the opening cycle is a write
    logic commit;     // posted write lands in the array on this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/strobe_mem_ctrl.sv
module strobe_mem_ctrl
  import strobe_mem_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         asN,
  input  logic         rwN,
  input  logic         udsN,
  input  logic         ldsN,
  output ctrlStrobes_t strobes,
  output logic         dtackN,
  output logic         rdOe
);

  typedef enum logic [0:0] {ST_IDLE, ST_ACKED} ctrlState_t;

  ctrlState_t stateQ, stateNext;
  logic       cycReadQ, cycReadNext;
  logic       pendWrQ;
  logic       anyLane;
  logic       startCyc;

  always_comb begin
    anyLane     = !udsN || !ldsN;
    startCyc    = (stateQ == ST_IDLE) && !asN && anyLane;
    stateNext   = stateQ;
    cycReadNext = cycReadQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (startCyc) begin
          stateNext   = ST_ACKED;
          cycReadNext = rwN;
        end
      end
      ST_ACKED: begin
        if (asN) begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      cycReadQ <= 1'b0;
      pendWrQ  <= 1'b0;
    end else begin
      stateQ   <= stateNext;
      cycReadQ <= cycReadNext;
      pendWrQ  <= startCyc && !rwN;
    end
  end

  always_comb begin
    strobes.capture   = startCyc;
    strobes.captureWr = startCyc && !rwN;
    strobes.commit    = pendWrQ;
  end

  assign dtackN = (stateQ != ST_ACKED);
  // Drive only while the master still holds the strobe
  assign rdOe   = (stateQ == ST_ACKED) && cycReadQ && !asN;

  // R2: acknowledge only answers an address strobe with a byte lane
  assert_ack_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackN) |-> $past(!asN && (!udsN || !ldsN)));

  // R4: bus driven only inside an acknowledged, strobed cycle
  assert_oe_in_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdOe |-> (!dtackN && !asN));

  // R5: strobe seen high while acknowledged closes the cycle
  assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!dtackN && asN) |=> dtackN);

  // R7: a commit follows a write capture by exactly one edge
  assert_commit_after_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureWr |=> strobes.commit);

endmodule

// File: rtl/strobe_mem_dpath.sv
module strobe_mem_dpath
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int FC_W      = 3,
  parameter int MEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              rwN,
  input  logic              udsN,
  input  logic              ldsN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [FC_W-1:0]   fc,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdWord,
  output logic [FC_W-1:0]   cycleFc
);

  localparam int IDX_W = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

  logic [IDX_W-1:0] capIdx;
  logic [LANES-1:0] laneSel;
  logic [BUS_W-1:0] laneFetch;

  // Posted write buffer
  logic [IDX_W-1:0] postIdxQ;
  logic [BUS_W-1:0] postDataQ;
  logic [LANES-1:0] postLaneQ;

  assign capIdx  = busAddr[IDX_W-1:0];
  assign laneSel = {!udsN, !ldsN};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postIdxQ  <= '0;
      postDataQ <= '0;
      postLaneQ <= '0;
    end else if (strobes.captureWr) begin
      postIdxQ  <= capIdx;
      postDataQ <= wrData;
      postLaneQ <= laneSel;
    end
  end

  // One storage column per byte lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] laneMem [MEM_WORDS];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < MEM_WORDS; w++) begin
          laneMem[w] <= '0;
        end
      end else if (strobes.commit && postLaneQ[l]) begin
        laneMem[postIdxQ] <= postDataQ[l*LANE_W +: LANE_W];
      end
    end

    assign laneFetch[l*LANE_W +: LANE_W] = laneMem[capIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWord  <= '0;
      cycleFc <= '0;
    end else if (strobes.capture) begin
      cycleFc <= fc;
      if (rwN) begin
        rdWord <= laneFetch;
      end
    end
  end

  // R8: a posted write never shares an edge with a new capture
  assert_commit_before_next_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> !strobes.capture);

  // R9: the registered function code moves only when a cycle opens
  assert_fc_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(cycleFc));

  // R7: a posted buffer always names at least one byte lane
  assert_post_has_lane_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> (postLaneQ != '0));

endmodule

// File: rtl/strobe_mem_slave.sv
module strobe_mem_slave
  import strobe_mem_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int FC_W      = 3,
  parameter int MEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              rwN,
  input  logic              udsN,
  input  logic              ldsN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [FC_W-1:0]   fc,
  input  logic [BUS_W-1:0]  wrData,
  output logic              dtackN,
  output logic [BUS_W-1:0]  rdData,
  output logic              rdOe,
  output logic [FC_W-1:0]   cycleFc
);

  ctrlStrobes_t     strobes;
  logic [BUS_W-1:0] rdWord;

  strobe_mem_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .asN     (asN),
    .rwN     (rwN),
    .udsN    (udsN),
    .ldsN    (ldsN),
    .strobes (strobes),
    .dtackN  (dtackN),
    .rdOe    (rdOe)
  );

  strobe_mem_dpath #(
    .ADDR_W    (ADDR_W),
    .FC_W      (FC_W),
    .MEM_WORDS (MEM_WORDS)
  ) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rwN     (rwN),
    .udsN    (udsN),
    .ldsN    (ldsN),
    .busAddr (busAddr),
    .fc      (fc),
    .wrData  (wrData),
    .rdWord  (rdWord),
    .cycleFc (cycleFc)
  );

  assign rdData = rdOe ? rdWord : '0;

  // R4: nothing on the data bus while it is released
  assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdOe |-> (rdData == '0));

endmodule

// File: tb/test_strobe_mem_slave.sv
module test_strobe_mem_slave;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 23;
  localparam int FC_W       = 3;
  localparam int MEM_WORDS  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              asN = 1'b1;
  logic              rwN = 1'b1;
  logic              udsN = 1'b1;
  logic              ldsN = 1'b1;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [FC_W-1:0]   fc = '0;
  logic [15:0]       wrData = '0;
  logic              dtackN;
  logic [15:0]       rdData;
  logic              rdOe;
  logic [FC_W-1:0]   cycleFc;

  int compared = 0;
  int mismatched = 0;

  strobe_mem_slave #(
    .ADDR_W(ADDR_W), .FC_W(FC_W), .MEM_WORDS(MEM_WORDS)
  ) i_strobe_mem_slave (
    .clk(clk), .rstN(rstN), .asN(asN), .rwN(rwN), .udsN(udsN), .ldsN(ldsN),
    .busAddr(busAddr), .fc(fc), .wrData(wrData),
    .dtackN(dtackN), .rdData(rdData), .rdOe(rdOe), .cycleFc(cycleFc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge
  logic [15:0]     mMem [MEM_WORDS];
  bit              mAck, mRead, mPend;
  logic [15:0]     mData, mPendData;
  logic [1:0]      mPendLane;
  int              mPendIdx;
  logic [FC_W-1:0] mFc;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 16'h0;
      mAck = 0; mRead = 0; mPend = 0; mData = 0; mFc = 0;
      mPendData = 0; mPendLane = 0; mPendIdx = 0;
    end else begin
      if (mPend) begin
        if (mPendLane[1]) mMem[mPendIdx][15:8] = mPendData[15:8];
        if (mPendLane[0]) mMem[mPendIdx][7:0]  = mPendData[7:0];
        mPend = 0;
      end
      if (!mAck) begin
        if (!asN && (!udsN || !ldsN)) begin
          mAck  = 1;
          mRead = rwN;
          mFc   = fc;
          if (rwN) begin
            mData = mMem[int'(busAddr) % MEM_WORDS];
          end else begin
            mPend     = 1;
            mPendIdx  = int'(busAddr) % MEM_WORDS;
            mPendData = wrData;
            mPendLane = {!udsN, !ldsN};
          end
        end
      end else if (asN) begin
        mAck = 0;
      end
    end
    #(CLK_PERIOD/4);
    cmp(rstN ? "R2/R5 dtackN" : "R1 dtackN", {31'h0, dtackN}, {31'h0, !mAck});
    cmp("R4 rdOe", {31'h0, rdOe}, {31'h0, mAck && mRead && !asN});
    cmp("R3 rdData", {16'h0, rdData}, (mAck && mRead && !asN) ? {16'h0, mData} : 32'h0);
    cmp("R9 cycleFc", {29'h0, cycleFc}, {29'h0, mFc});
  end

  // Read cycle; optionally moves the address and lanes mid-cycle (R11)
  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [FC_W-1:0] f,
                         input bit wiggle, output logic [15:0] got);
    @(negedge clk);
    asN = 0; rwN = 1; udsN = 0; ldsN = 0; busAddr = a; fc = f;
    @(negedge clk);
    if (wiggle) begin
      busAddr = ~a; udsN = 1; rwN = 0; fc = ~f;
    end
    @(negedge clk);
    got = rdData;
    asN = 1; udsN = 1; ldsN = 1; rwN = 1;
    #1;
    cmp("R4 oe drops with strobe", {31'h0, rdOe}, 32'h0);
    cmp("R5 ack still low after release", {31'h0, dtackN}, 32'h0);
    @(posedge clk); #1;
    cmp("R5 ack released", {31'h0, dtackN}, 32'h1);
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [FC_W-1:0] f,
                          input logic [15:0] d, input bit upper, input bit lower);
    @(negedge clk);
    asN = 0; rwN = 0; udsN = !upper; ldsN = !lower; busAddr = a; fc = f; wrData = d;
    @(negedge clk);
    cmp("R4 no drive on write", {31'h0, rdOe}, 32'h0);
    cmp("R2 write acked", {31'h0, dtackN}, 32'h0);
    wrData = ~d;  // R6: late data must be ignored
    @(negedge clk);
    asN = 1; udsN = 1; ldsN = 1; rwN = 1;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] got;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    cmp("R1 dtackN after reset", {31'h0, dtackN}, 32'h1);
    cmp("R1 rdData after reset", {16'h0, rdData}, 32'h0);
    busRead(23'd0, 3'd5, 0, got);
    cmp("R1 word 0 cleared", {16'h0, got}, 32'h0);
    busRead(23'd15, 3'd5, 0, got);
    cmp("R1 word 15 cleared", {16'h0, got}, 32'h0);

    busWrite(23'd3, 3'd1, 16'h1234, 1, 1);
    busRead(23'd3, 3'd2, 0, got);
    cmp("R7 full write", {16'h0, got}, 32'h1234);
    cmp("R9 fc captured", {29'h0, cycleFc}, 32'd2);

    busWrite(23'd3, 3'd1, 16'hABCD, 1, 0);
    busRead(23'd3, 3'd2, 0, got);
    cmp("R7 upper lane only", {16'h0, got}, 32'hAB34);
    busWrite(23'd3, 3'd1, 16'h55EF, 0, 1);
    busRead(23'd3, 3'd2, 0, got);
    cmp("R7 R6 lower lane only", {16'h0, got}, 32'hABEF);

    // R8: read opens on the edge right after the write closes
    @(negedge clk);
    asN = 0; rwN = 0; udsN = 0; ldsN = 0; busAddr = 23'd7; wrData = 16'hC0DE;
    @(negedge clk);
    asN = 1; udsN = 1; ldsN = 1;
    @(negedge clk);
    asN = 0; rwN = 1; udsN = 0; ldsN = 0; busAddr = 23'd7;
    @(negedge clk);
    cmp("R8 read after posted write", {16'h0, rdData}, 32'hC0DE);
    asN = 1; udsN = 1; ldsN = 1;
    @(negedge clk);

    busRead(23'd3 + 23'd16, 3'd4, 0, got);
    cmp("R10 alias above index", {16'h0, got}, 32'hABEF);
    busWrite(23'h7FFFF5, 3'd6, 16'h0F0F, 1, 1);
    busRead(23'd5, 3'd6, 0, got);
    cmp("R10 high address bits ignored", {16'h0, got}, 32'h0F0F);

    busRead(23'd3, 3'd3, 1, got);
    cmp("R11 mid-cycle changes ignored", {16'h0, got}, 32'hABEF);
    cmp("R11 R9 fc from cycle start", {29'h0, cycleFc}, 32'd3);

    // R2: strobe without any byte lane is not answered
    @(negedge clk);
    asN = 0; rwN = 1; udsN = 1; ldsN = 1; busAddr = 23'd3; fc = 3'd7;
    repeat (3) @(negedge clk);
    cmp("R2 no lane no ack", {31'h0, dtackN}, 32'h1);
    cmp("R9 fc unchanged without cycle", {29'h0, cycleFc}, 32'd3);
    asN = 1;
    @(negedge clk);

    for (int w = 0; w < MEM_WORDS; w++) busWrite(23'(w), 3'd1, 16'(w * 16'h0101 + 1), 1, 1);
    for (int w = 0; w < MEM_WORDS; w++) begin
      busRead(23'(w), 3'd0, 0, got);
      cmp("R7 sweep readback", {16'h0, got}, {16'h0, 16'(w * 16'h0101 + 1)});
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule